// File: doc/BRIEF.md
# Timer Register Decoder

This block is the register front end of a multi-channel timer. A host issues single-cycle requests carrying a direction, a byte size, a byte address and 64 bits of write data. Each register is 64 bits wide, and a request may cover the whole register or one 32-bit half of it. The decoder merges a half-width write into the full register. It keeps read-only fields at their fixed values and forces a few control bits to zero. It answers every request one cycle later with an acknowledge and registered read data.

The general configuration word and the per-channel configuration and message words are held in this block. The counter value, the interrupt status vector and the comparator values live in the neighbouring counting and interrupt blocks, and the decoder reads them through input ports. When one of those is written, the decoder sends a one-cycle strobe with the merged data. Register offsets: identity word 0x000, general configuration 0x010, interrupt status 0x020, counter 0x0F0. Channel n starts at 0x100 + 32·n and holds its configuration word at +0x00, its comparator at +0x08 and its message word at +0x10.

Top module: `tmr_regif`

## Requirements
- R1: Only sizes of 4 and 8 bytes are legal; a write of any other size changes no register and raises no strobe, and a read of any other size returns zero.
- R2: An access whose address is not a multiple of its size is dropped on write and reads zero.
- R3: A 4-byte access with address bit 2 set targets bits 63:32 of the register: the write data's low 32 bits land there, and a read returns those bits in respRdata[31:0] with the upper 32 bits zero; with bit 2 clear, the low half is used the same way.
- R4: A write yields (old AND NOT mask) OR (data AND mask), where the mask covers both halves for 8 bytes and only the addressed half for 4 bytes.
- R5: In a channel configuration word, bits 63:32 (route capability), bit 15 (message capability), bit 5 (size capability) and bit 4 (periodic capability) keep their reset values under any write, and bit 8 (32-bit mode) is always zero; reset value is {ROUTE_CAP, 0x00008010}.
- R6: Bit 1 (legacy routing) of the general configuration word always reads zero; other bits are stored as written.
- R7: The identity word at 0x000 reads {TICK_FS, VENDOR_ID, 3'b000, NUM_CH-1, 8'h01} (revision 1, counter-size bit 13 zero) and ignores writes.
- R8: A counter write merges into {32'b0, cntValue} and emits the low 32 bits on cntWrData with a cntWrStb pulse.
- R9: Every request gets respAck exactly one cycle later; read data is registered and zero when no legal read was made; unmapped offsets read zero and writes to them have no effect.
- R10: An interrupt status write pulses isrClrStb with isrClrMask = (written data AND mask)[NUM_CH-1:0] AND isrValue; the status reads back as the zero-extended isrValue.
- R11: A comparator write to channel n pulses cmpWrStb[n] with the low 32 bits of the write merged into {32'b0, comparator n}; a comparator read returns that value zero-extended.
- R12: Strobes last one cycle, coincide with respAck, and at most one is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 write, 0 read |
| reqSize | input | 4 | Access size in bytes |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 64 | Write data |
| respAck | output | 1 | Acknowledge, one cycle after request |
| respRdata | output | 64 | Registered read data |
| cntValue | input | 32 | Current counter value |
| isrValue | input | NUM_CH | Current interrupt status bits |
| cmpValueFlat | input | NUM_CH*32 | Comparator values, channel n at bits 32n+31:32n |
| genCfg | output | 64 | Stored general configuration |
| chCfgFlat | output | NUM_CH*64 | Stored channel configuration words |
| chMsgFlat | output | NUM_CH*64 | Stored channel message words |
| cfgWrStb | output | 1 | General configuration written |
| cntWrStb | output | 1 | Counter write strobe |
| cntWrData | output | 32 | Merged counter value |
| isrClrStb | output | 1 | Status clear strobe |
| isrClrMask | output | NUM_CH | Status bits to clear |
| chCfgWrStb | output | NUM_CH | Channel configuration written |
| cmpWrStb | output | NUM_CH | Comparator write strobe per channel |
| cmpWrData | output | 32 | Merged comparator value |

## Verification
The merge is driven with 8-byte writes, with 4-byte writes to the low half and with 4-byte writes to the high half. This shows whether the data shift and the half mask are applied to the correct side. Illegal sizes (1 and 2) and misaligned addresses are mixed in to show that a dropped access leaves state and strobes untouched. All-ones and all-zeros patterns into the channel configuration words show whether the protected fields and the forced-zero bit hold up from either direction. Counter, status and comparator writes use external values whose halves differ, so a merge against the wrong old value shows up in the strobe data.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

  localparam int CH_IDX_W     = 5;
  localparam int CH_STRIDE_SH = 5;
  localparam int CH_STRIDE    = 32;

  localparam int OFF_CAP     = 'h000;
  localparam int OFF_CFG     = 'h010;
  localparam int OFF_ISR     = 'h020;
  localparam int OFF_CNT     = 'h0F0;
  localparam int OFF_CH_BASE = 'h100;

  localparam int CFG_LEGACY_BIT = 1;
  localparam int CH_PERCAP_BIT  = 4;
  localparam int CH_MODE32_BIT  = 8;
  localparam int CH_MSGCAP_BIT  = 15;

  // route capability, message capability, size capability, periodic capability
  localparam logic [63:0] CH_RO_MASK = 64'hFFFF_FFFF_0000_8030;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAP,
    SEL_CFG,
    SEL_ISR,
    SEL_CNT,
    SEL_CHCFG,
    SEL_CHCMP,
    SEL_CHMSG
  } regSel_e;

  typedef struct packed {
    logic                rdEn;
    logic                wrEn;
    regSel_e             sel;
    logic [CH_IDX_W-1:0] ch;
    logic                narrow;
    logic                upper;
  } accCmd_t;

  function automatic logic [63:0] mergeWord(input logic [63:0] oldVal,
                                            input logic [63:0] newVal,
                                            input logic [63:0] mask);
    return (oldVal & ~mask) | (newVal & mask);
  endfunction

endpackage

// File: rtl/tmr_regif_ctrl.sv
module tmr_regif_ctrl
  import tmr_regif_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [3:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  output accCmd_t           cmd,
  output logic              respAck
);

  localparam logic [ADDR_W-1:0] A_CAP     = ADDR_W'(OFF_CAP);
  localparam logic [ADDR_W-1:0] A_CFG     = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_ISR     = ADDR_W'(OFF_ISR);
  localparam logic [ADDR_W-1:0] A_CNT     = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_CH_BASE = ADDR_W'(OFF_CH_BASE);
  localparam logic [ADDR_W-1:0] A_CH_END  = ADDR_W'(OFF_CH_BASE + NUM_CH * CH_STRIDE);

  logic              isWide;
  logic              isNarrow;
  logic              aligned;
  logic              legal;
  logic [ADDR_W-1:0] regAddr;
  logic [ADDR_W-1:0] relAddr;
  regSel_e           sel;
  logic [CH_IDX_W-1:0] chIdx;

  always_comb begin
    isWide   = (reqSize == 4'd8);
    isNarrow = (reqSize == 4'd4);
    aligned  = isWide ? (reqAddr[2:0] == 3'b000) : (reqAddr[1:0] == 2'b00);
    legal    = reqValid && (isWide || isNarrow) && aligned;
    regAddr  = {reqAddr[ADDR_W-1:3], 3'b000};
    relAddr  = regAddr - A_CH_BASE;
    sel      = SEL_NONE;
    chIdx    = '0;
    if (regAddr == A_CAP)      sel = SEL_CAP;
    else if (regAddr == A_CFG) sel = SEL_CFG;
    else if (regAddr == A_ISR) sel = SEL_ISR;
    else if (regAddr == A_CNT) sel = SEL_CNT;
    else if (regAddr >= A_CH_BASE && regAddr < A_CH_END) begin
      chIdx = relAddr[CH_IDX_W+CH_STRIDE_SH-1:CH_STRIDE_SH];
      case (relAddr[4:3])
        2'd0:    sel = SEL_CHCFG;
        2'd1:    sel = SEL_CHCMP;
        2'd2:    sel = SEL_CHMSG;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    cmd.rdEn   = legal && !reqWrite && (sel != SEL_NONE);
    cmd.wrEn   = legal && reqWrite && (sel != SEL_NONE) && (sel != SEL_CAP);
    cmd.sel    = sel;
    cmd.ch     = chIdx;
    cmd.narrow = isNarrow;
    cmd.upper  = reqAddr[2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respAck <= 1'b0;
    else       respAck <= reqValid;
  end

endmodule

// File: rtl/tmr_regif_dp.sv
module tmr_regif_dp
  import tmr_regif_pkg::*;
#(
  parameter int          NUM_CH    = 8,
  parameter logic [15:0] VENDOR_ID = 16'h1D0F,
  parameter logic [31:0] TICK_FS   = 32'd59604644,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  accCmd_t               cmd,
  input  logic [63:0]           reqWdata,
  input  logic [31:0]           cntValue,
  input  logic [NUM_CH-1:0]     isrValue,
  input  logic [NUM_CH*32-1:0]  cmpValueFlat,
  output logic [63:0]           respRdata,
  output logic [63:0]           genCfg,
  output logic [NUM_CH*64-1:0]  chCfgFlat,
  output logic [NUM_CH*64-1:0]  chMsgFlat,
  output logic                  cfgWrStb,
  output logic                  cntWrStb,
  output logic [31:0]           cntWrData,
  output logic                  isrClrStb,
  output logic [NUM_CH-1:0]     isrClrMask,
  output logic [NUM_CH-1:0]     chCfgWrStb,
  output logic [NUM_CH-1:0]     cmpWrStb,
  output logic [31:0]           cmpWrData
);

  localparam int          CH_SEL_W  = $clog2(NUM_CH);
  localparam logic [4:0]  CH_COUNT  = 5'(NUM_CH - 1);
  localparam logic [63:0] CAP_VALUE = {TICK_FS, VENDOR_ID, 3'b000, CH_COUNT, 8'h01};
  localparam logic [63:0] CH_RESET  = {ROUTE_CAP, 32'h0}
                                    | (64'd1 << CH_PERCAP_BIT)
                                    | (64'd1 << CH_MSGCAP_BIT);
  localparam logic [63:0] CH_FORCE0 = CH_RO_MASK | (64'd1 << CH_MODE32_BIT);

  logic [CH_SEL_W-1:0] chSel;
  logic                loEn;
  logic                hiEn;
  logic [63:0]         wrMask;
  logic [63:0]         wrData;
  logic [63:0]         wrBits;
  logic [31:0]         cmpSel;
  logic [63:0]         oldVal;
  logic [63:0]         merged;
  logic [63:0]         cfgNext;
  logic [63:0]         chCfgNext;
  logic [63:0]         rdShaped;
  logic [NUM_CH-1:0]   chHit;
  logic [63:0]         chCfgArr [NUM_CH];
  logic [63:0]         chMsgArr [NUM_CH];
  logic [63:0]         genCfgQ;

  always_comb begin
    chSel  = cmd.ch[CH_SEL_W-1:0];
    loEn   = !cmd.narrow || !cmd.upper;
    hiEn   = !cmd.narrow || cmd.upper;
    wrMask = {{32{hiEn}}, {32{loEn}}};
    wrData = (cmd.narrow && cmd.upper) ? {reqWdata[31:0], 32'h0} : reqWdata;
    wrBits = wrData & wrMask;
    cmpSel = cmpValueFlat[{chSel, 5'b00000} +: 32];
    case (cmd.sel)
      SEL_CAP:   oldVal = CAP_VALUE;
      SEL_CFG:   oldVal = genCfgQ;
      SEL_ISR:   oldVal = {{(64-NUM_CH){1'b0}}, isrValue};
      SEL_CNT:   oldVal = {32'h0, cntValue};
      SEL_CHCFG: oldVal = chCfgArr[chSel];
      SEL_CHCMP: oldVal = {32'h0, cmpSel};
      SEL_CHMSG: oldVal = chMsgArr[chSel];
      default:   oldVal = 64'h0;
    endcase
    merged    = mergeWord(oldVal, wrData, wrMask);
    cfgNext   = merged & ~(64'd1 << CFG_LEGACY_BIT);
    chCfgNext = (merged & ~CH_FORCE0) | (oldVal & CH_RO_MASK);
    rdShaped  = cmd.narrow ? {32'h0, (cmd.upper ? oldVal[63:32] : oldVal[31:0])} : oldVal;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [63:0] cfgQ;
    logic [63:0] msgQ;

    assign chHit[g] = (chSel == CH_SEL_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ <= CH_RESET;
        msgQ <= 64'h0;
      end else if (cmd.wrEn && chHit[g]) begin
        if (cmd.sel == SEL_CHCFG) cfgQ <= chCfgNext;
        if (cmd.sel == SEL_CHMSG) msgQ <= merged;
      end
    end

    assign chCfgArr[g]          = cfgQ;
    assign chMsgArr[g]          = msgQ;
    assign chCfgFlat[g*64 +: 64] = cfgQ;
    assign chMsgFlat[g*64 +: 64] = msgQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genCfgQ    <= 64'h0;
      respRdata  <= 64'h0;
      cfgWrStb   <= 1'b0;
      cntWrStb   <= 1'b0;
      cntWrData  <= 32'h0;
      isrClrStb  <= 1'b0;
      isrClrMask <= '0;
      chCfgWrStb <= '0;
      cmpWrStb   <= '0;
      cmpWrData  <= 32'h0;
    end else begin
      respRdata  <= cmd.rdEn ? rdShaped : 64'h0;
      cfgWrStb   <= cmd.wrEn && (cmd.sel == SEL_CFG);
      cntWrStb   <= cmd.wrEn && (cmd.sel == SEL_CNT);
      isrClrStb  <= cmd.wrEn && (cmd.sel == SEL_ISR);
      chCfgWrStb <= (cmd.wrEn && (cmd.sel == SEL_CHCFG)) ? chHit : '0;
      cmpWrStb   <= (cmd.wrEn && (cmd.sel == SEL_CHCMP)) ? chHit : '0;
      if (cmd.wrEn && (cmd.sel == SEL_CFG)) genCfgQ <= cfgNext;
      if (cmd.wrEn && (cmd.sel == SEL_CNT)) cntWrData <= merged[31:0];
      if (cmd.wrEn && (cmd.sel == SEL_CHCMP)) cmpWrData <= merged[31:0];
      if (cmd.wrEn && (cmd.sel == SEL_ISR)) isrClrMask <= wrBits[NUM_CH-1:0] & isrValue;
    end
  end

  assign genCfg = genCfgQ;

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          NUM_CH    = 8,
  parameter logic [15:0] VENDOR_ID = 16'h1D0F,
  parameter logic [31:0] TICK_FS   = 32'd59604644,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [3:0]            reqSize,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [63:0]           reqWdata,
  output logic                  respAck,
  output logic [63:0]           respRdata,
  input  logic [31:0]           cntValue,
  input  logic [NUM_CH-1:0]     isrValue,
  input  logic [NUM_CH*32-1:0]  cmpValueFlat,
  output logic [63:0]           genCfg,
  output logic [NUM_CH*64-1:0]  chCfgFlat,
  output logic [NUM_CH*64-1:0]  chMsgFlat,
  output logic                  cfgWrStb,
  output logic                  cntWrStb,
  output logic [31:0]           cntWrData,
  output logic                  isrClrStb,
  output logic [NUM_CH-1:0]     isrClrMask,
  output logic [NUM_CH-1:0]     chCfgWrStb,
  output logic [NUM_CH-1:0]     cmpWrStb,
  output logic [31:0]           cmpWrData
);

  accCmd_t cmd;

  tmr_regif_ctrl #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqAddr  (reqAddr),
    .cmd      (cmd),
    .respAck  (respAck)
  );

  tmr_regif_dp #(
    .NUM_CH    (NUM_CH),
    .VENDOR_ID (VENDOR_ID),
    .TICK_FS   (TICK_FS),
    .ROUTE_CAP (ROUTE_CAP)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .reqWdata     (reqWdata),
    .cntValue     (cntValue),
    .isrValue     (isrValue),
    .cmpValueFlat (cmpValueFlat),
    .respRdata    (respRdata),
    .genCfg       (genCfg),
    .chCfgFlat    (chCfgFlat),
    .chMsgFlat    (chMsgFlat),
    .cfgWrStb     (cfgWrStb),
    .cntWrStb     (cntWrStb),
    .cntWrData    (cntWrData),
    .isrClrStb    (isrClrStb),
    .isrClrMask   (isrClrMask),
    .chCfgWrStb   (chCfgWrStb),
    .cmpWrStb     (cmpWrStb),
    .cmpWrData    (cmpWrData)
  );

endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk #(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqWrite,
  input logic [3:0]           reqSize,
  input logic [ADDR_W-1:0]    reqAddr,
  input logic                 respAck,
  input logic [63:0]          respRdata,
  input logic [63:0]          genCfg,
  input logic [NUM_CH*64-1:0] chCfgFlat,
  input logic                 cfgWrStb,
  input logic                 cntWrStb,
  input logic                 isrClrStb,
  input logic [NUM_CH-1:0]    chCfgWrStb,
  input logic [NUM_CH-1:0]    cmpWrStb
);

  logic [NUM_CH-1:0] mode32Bits;
  logic [2*NUM_CH+2:0] stbVec;
  logic badSizeRead;
  logic misalignRead;
  logic cfgWrite;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) mode32Bits[i] = chCfgFlat[i*64 + 8];
    stbVec       = {cfgWrStb, cntWrStb, isrClrStb, chCfgWrStb, cmpWrStb};
    badSizeRead  = reqValid && !reqWrite && (reqSize != 4'd4) && (reqSize != 4'd8);
    misalignRead = reqValid && !reqWrite &&
                   (((reqSize == 4'd8) && (reqAddr[2:0] != 3'b000)) ||
                    ((reqSize == 4'd4) && (reqAddr[1:0] != 2'b00)));
    cfgWrite     = reqValid && reqWrite && (reqAddr == ADDR_W'('h010)) && (reqSize == 4'd8);
  end

  // R9
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respAck);

  // R9
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respAck);

  // R1
  bad_size_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    badSizeRead |=> (respRdata == 64'h0));

  // R2
  misalign_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    misalignRead |=> (respRdata == 64'h0));

  // R6
  legacy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> !genCfg[1]);

  // R5
  mode32_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(mode32Bits) == 0);

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbVec));

  // R12
  strobe_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stbVec != '0) |-> respAck);

  // R8
  cnt_strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrStb |-> $past(reqValid && reqWrite));

endmodule

bind tmr_regif tmr_regif_chk #(
  .ADDR_W (ADDR_W),
  .NUM_CH (NUM_CH)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqSize    (reqSize),
  .reqAddr    (reqAddr),
  .respAck    (respAck),
  .respRdata  (respRdata),
  .genCfg     (genCfg),
  .chCfgFlat  (chCfgFlat),
  .cfgWrStb   (cfgWrStb),
  .cntWrStb   (cntWrStb),
  .isrClrStb  (isrClrStb),
  .chCfgWrStb (chCfgWrStb),
  .cmpWrStb   (cmpWrStb)
);

// File: tb/tmr_regif_tb.sv
`timescale 1ns/1ps
module tmr_regif_tb;

  localparam int NCH = 8;
  localparam int AW  = 12;
  localparam logic [63:0] CAPV  = {32'd59604644, 16'h1D0F, 3'b000, 5'd7, 8'h01};
  localparam logic [63:0] CHRST = 64'h00F0_0000_0000_8010;
  localparam logic [63:0] ROM   = 64'hFFFF_FFFF_0000_8030;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rstN;
  logic                reqValid, reqWrite;
  logic [3:0]          reqSize;
  logic [AW-1:0]       reqAddr;
  logic [63:0]         reqWdata;
  logic                respAck;
  logic [63:0]         respRdata;
  logic [31:0]         cntValue;
  logic [NCH-1:0]      isrValue;
  logic [NCH*32-1:0]   cmpValueFlat;
  logic [63:0]         genCfg;
  logic [NCH*64-1:0]   chCfgFlat, chMsgFlat;
  logic                cfgWrStb, cntWrStb, isrClrStb;
  logic [31:0]         cntWrData, cmpWrData;
  logic [NCH-1:0]      isrClrMask, chCfgWrStb, cmpWrStb;

  tmr_regif #(.ADDR_W(AW), .NUM_CH(NCH)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .respAck(respAck), .respRdata(respRdata), .cntValue(cntValue),
    .isrValue(isrValue), .cmpValueFlat(cmpValueFlat), .genCfg(genCfg),
    .chCfgFlat(chCfgFlat), .chMsgFlat(chMsgFlat), .cfgWrStb(cfgWrStb),
    .cntWrStb(cntWrStb), .cntWrData(cntWrData), .isrClrStb(isrClrStb),
    .isrClrMask(isrClrMask), .chCfgWrStb(chCfgWrStb), .cmpWrStb(cmpWrStb),
    .cmpWrData(cmpWrData)
  );

  int checks = 0;
  int errors = 0;

  // reference state
  logic [63:0] mCfg;
  logic [63:0] mChCfg [NCH];
  logic [63:0] mChMsg [NCH];
  // expected outputs for the next compare
  logic        eAck;
  logic [63:0] eRdata;
  logic        eCfgStb, eCntStb, eIsrStb;
  logic [31:0] eCntData, eCmpData;
  logic [NCH-1:0] eIsrMask, eChCfgStb, eCmpStb;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearExp();
    eAck = 0; eRdata = 0; eCfgStb = 0; eCntStb = 0; eIsrStb = 0;
    eChCfgStb = 0; eCmpStb = 0;
  endtask

  task automatic compareAll(input string req);
    chk("R9", "ack", 64'(respAck), 64'(eAck));
    chk(req, "rdata", respRdata, eRdata);
    chk("R12", "strobes", 64'({cfgWrStb, cntWrStb, isrClrStb, chCfgWrStb, cmpWrStb}),
        64'({eCfgStb, eCntStb, eIsrStb, eChCfgStb, eCmpStb}));
    if (eCntStb) chk("R8", "cntWrData", 64'(cntWrData), 64'(eCntData));
    if (eIsrStb) chk("R10", "isrClrMask", 64'(isrClrMask), 64'(eIsrMask));
    if (eCmpStb != 0) chk("R11", "cmpWrData", 64'(cmpWrData), 64'(eCmpData));
    chk(req, "genCfg", genCfg, mCfg);
    for (int i = 0; i < NCH; i++) begin
      chk(req, $sformatf("chCfg%0d", i), chCfgFlat[i*64 +: 64], mChCfg[i]);
      chk(req, $sformatf("chMsg%0d", i), chMsgFlat[i*64 +: 64], mChMsg[i]);
    end
  endtask

  task automatic access(input string req, input bit wr, input int size,
                        input int addr, input logic [63:0] wd);
    bit legal, upper;
    int base, kind, ch;
    logic [63:0] mask, data, oldv, nv;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqSize = 4'(size);
    reqAddr = AW'(addr); reqWdata = wd;
    clearExp();
    legal = (size == 4 || size == 8) && (addr % size == 0);
    upper = (size == 4) && ((addr / 4) % 2 == 1);
    mask  = (size == 8) ? '1 : (upper ? 64'hFFFF_FFFF_0000_0000 : 64'h0000_0000_FFFF_FFFF);
    data  = upper ? (wd << 32) : wd;
    base  = addr - (addr % 8);
    kind  = 0; ch = 0; oldv = 0;
    if (base == 'h000) begin kind = 1; oldv = CAPV; end
    else if (base == 'h010) begin kind = 2; oldv = mCfg; end
    else if (base == 'h020) begin kind = 3; oldv = 64'(isrValue); end
    else if (base == 'h0F0) begin kind = 4; oldv = 64'(cntValue); end
    else if (base >= 'h100 && base < 'h100 + NCH * 32) begin
      ch = (base - 'h100) / 32;
      case (((base - 'h100) % 32) / 8)
        0: begin kind = 5; oldv = mChCfg[ch]; end
        1: begin kind = 6; oldv = 64'(cmpValueFlat[ch*32 +: 32]); end
        2: begin kind = 7; oldv = mChMsg[ch]; end
        default: kind = 0;
      endcase
    end
    eAck = 1;
    if (!wr && legal && kind != 0)
      eRdata = (size == 8) ? oldv : (upper ? (oldv >> 32) : (oldv & 64'hFFFF_FFFF));
    nv = (oldv & ~mask) | (data & mask);
    if (wr && legal) begin
      case (kind)
        2: begin mCfg = nv & ~64'h2; eCfgStb = 1; end
        3: begin eIsrStb = 1; eIsrMask = NCH'(data & mask) & isrValue; end
        4: begin eCntStb = 1; eCntData = nv[31:0]; end
        5: begin mChCfg[ch] = (nv & ~(ROM | 64'h100)) | (oldv & ROM); eChCfgStb[ch] = 1; end
        6: begin eCmpStb[ch] = 1; eCmpData = nv[31:0]; end
        7: mChMsg[ch] = nv;
        default: ;
      endcase
    end
    @(negedge clk);
    reqValid = 0;
    compareAll(req);
    clearExp();
    @(negedge clk);
    compareAll(req);
  endtask

  initial begin
    #(20ns * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; reqValid = 0; reqWrite = 0; reqSize = 0; reqAddr = 0; reqWdata = 0;
    cntValue = 32'hDEAD_BEEF; isrValue = 8'hA6;
    for (int i = 0; i < NCH; i++) cmpValueFlat[i*32 +: 32] = 32'h1000_0000 + 32'(i * 'h111);
    mCfg = 0;
    for (int i = 0; i < NCH; i++) begin mChCfg[i] = CHRST; mChMsg[i] = 0; end
    clearExp(); eIsrMask = 0; eCntData = 0; eCmpData = 0;
    repeat (3) @(negedge clk);
    compareAll("R5");               // reset state
    rstN = 1;
    @(negedge clk);
    compareAll("R9");

    // R7 identity word
    access("R7", 0, 8, 'h000, 0);
    access("R3", 0, 4, 'h004, 0);
    access("R3", 0, 4, 'h000, 0);
    access("R7", 1, 8, 'h000, '1);
    access("R7", 0, 8, 'h000, 0);

    // R6 / R4 general configuration
    access("R6", 1, 8, 'h010, 64'hFFFF_0000_1234_0003);
    access("R6", 0, 8, 'h010, 0);
    access("R4", 1, 4, 'h014, 64'h7777_7777_A5A5_A5A5);
    access("R4", 1, 4, 'h010, 64'h5555_5555_0000_00FE);
    access("R3", 0, 4, 'h014, 0);

    // R1 illegal sizes, R2 misalignment
    access("R1", 1, 2, 'h010, 64'h0);
    access("R1", 1, 1, 'h010, 64'h0);
    access("R1", 0, 1, 'h010, 0);
    access("R1", 0, 2, 'h010, 0);
    access("R2", 1, 8, 'h014, 64'h0);
    access("R2", 0, 8, 'h014, 0);
    access("R2", 1, 4, 'h012, 64'h0);
    access("R2", 0, 4, 'h016, 0);

    // R5 channel configuration protection
    access("R5", 1, 8, 'h140, '1);
    access("R5", 0, 8, 'h140, 0);
    access("R5", 1, 4, 'h1E4, 64'h0);
    access("R5", 1, 8, 'h120, 64'h0);
    access("R5", 1, 4, 'h100, 64'hFFFF_FFFF);

    // R8 counter writes
    access("R8", 1, 4, 'h0F0, 64'h1234_5678);
    access("R8", 1, 4, 'h0F4, 64'hCAFE_F00D);
    access("R8", 1, 8, 'h0F0, 64'h0BAD_0000_8765_4321);
    access("R8", 0, 4, 'h0F4, 0);
    access("R8", 0, 8, 'h0F0, 0);

    // R10 status clear
    access("R10", 1, 8, 'h020, 64'h0000_0000_0000_FF0F);
    access("R10", 1, 4, 'h024, 64'hFFFF_FFFF);
    isrValue = 8'h5B;
    access("R10", 1, 4, 'h020, 64'hFF);
    access("R10", 0, 8, 'h020, 0);

    // R11 comparator
    access("R11", 1, 4, 'h1A8, 64'h0000_ABCD);
    access("R11", 1, 4, 'h1AC, 64'h1111_2222);
    access("R11", 1, 8, 'h128, 64'hFFFF_0000_5555_AAAA);
    access("R11", 0, 8, 'h168, 0);
    access("R11", 0, 4, 'h1EC, 0);

    // R4 message words
    access("R4", 1, 8, 'h190, 64'h0123_4567_89AB_CDEF);
    access("R4", 1, 4, 'h194, 64'hFEED_FACE);
    access("R4", 0, 8, 'h190, 0);
    access("R4", 1, 4, 'h1F0, 64'h3C3C_3C3C);

    // R9 unmapped offsets
    access("R9", 0, 8, 'h080, 0);
    access("R9", 1, 8, 'h080, '1);
    access("R9", 0, 8, 'h200, 0);
    access("R9", 1, 8, 'h118, '1);
    access("R9", 0, 8, 'h118, 0);
    access("R9", 1, 8, 'h300, '1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule